// File: doc/BRIEF.md
# Synchronous Selectable Clock Divider

This block divides one input clock into two aligned outputs. One output always runs at half the input rate. The second output runs at one quarter or one sixth of the input rate, chosen by a select input, and always has an even duty cycle. Both outputs come from one shared position counter, so every rising edge of the slower output falls on the same input edge as a rising edge of the half-rate output. A phase output pulses for one input cycle whenever both outputs have just risen together. A receiving system can use this pulse to line up other logic with the divided clocks.

An active-low enable starts and stops the dividers. The enable is captured on the falling edge of the input clock and acts at the next rising edge. While the dividers are stopped, the outputs are held low and the counter position is frozen. Counting resumes from the frozen position, so the two outputs never lose their alignment. A change of the select input waits for the next common rising edge, so no period of the slower output is ever cut short.

An active-high master reset clears every output at once. Its release passes through a short synchroniser, so several copies of the block reset together start in lockstep. When all control inputs are left at logic 0, the block comes out of reset dividing by four.

Top module: `sel_clock_divider`

## Requirements
- R1: While the dividers run, `div2_o` changes level on every rising edge of `clk_i` (period of 2 input cycles).
- R2: With `sel6_i` = 0, `div46_o` has a period of 4 input cycles (2 high, 2 low). With `sel6_i` = 1, the period is 6 input cycles (3 high, 3 low).
- R3: During uninterrupted running, every rising edge of `div46_o` falls on the same input edge as a rising edge of `div2_o`.
- R4: `phase_o` is high for exactly the one input cycle that follows an edge on which both `div2_o` and `div46_o` rose together. It is low at all other times and is never high for two cycles in a row.
- R5: A new value of `sel6_i` takes effect only at the next coincident rising edge. The period already under way completes with the old ratio.
- R6: `en_n_i` is sampled on each falling edge of `clk_i` and acts at the following rising edge. The outputs change only at rising edges.
- R7: While the sampled enable is inactive (`en_n_i` = 1), all three outputs are low and the counter position is held. On re-enable, counting continues from the held position.
- R8: Raising `mreset_i` drives all outputs low at once, without waiting for a clock edge. After release, the first coincident rise, together with a `phase_o` pulse, appears at the third rising edge of `clk_i`.
- R9: With `en_n_i`, `mreset_i` and `sel6_i` all at 0, the block divides by four directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock that drives every register |
| mreset_i | input | 1 | Master reset, active high; asserts asynchronously and is released synchronously |
| en_n_i | input | 1 | Common enable, active low, sampled on the falling clock edge |
| sel6_i | input | 1 | Ratio select for the slower output: 0 divides by 4, 1 divides by 6 |
| div2_o | output | 1 | Registered divide-by-2 output |
| div46_o | output | 1 | Registered divide-by-4 or divide-by-6 output |
| phase_o | output | 1 | One-cycle pulse after a coincident rise of both outputs |

## Verification
The hardest situations to reach are the ones where the frozen counter position is not a period boundary. These are re-enabling after a stop in the middle of a period, and changing the ratio in the middle of a period. The stimulus reaches them by first locking onto a `phase_o` pulse, so the counter position is known. It then stops the dividers or flips the select a set number of cycles later. The expected output sequence, including a coincident rise away from the normal boundary, follows from counting those cycles. A stretch of random enable toggling follows. The dividers must then settle back to full, unshortened periods, with the phase pulse still marking only true coincident rises.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Ratio chosen for the slower divided output.
  typedef enum logic {
    RATIO_LO = 1'b0,
    RATIO_HI = 1'b1
  } ratio_e;

endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
// Master reset: clears at once, releases after SYNC_STAGES rising edges.
module clkdiv_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic mreset_i,
  output logic rst_n_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or posedge mreset_i) begin
    if (mreset_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/clkdiv_en_capture.sv
`timescale 1ns/1ps
// Enable flop on the falling edge, so the divider state only starts or
// stops while the input clock is low.
module clkdiv_en_capture (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic en_n_i,
  output logic run_o
);

  logic run_q;
  logic run_d;

  always_comb run_d = ~en_n_i;

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  assign run_o = run_q;

endmodule

// File: rtl/clkdiv_phase_ctr.sv
`timescale 1ns/1ps
// Shared position counter. Both outputs decode one position, which keeps
// them aligned. The ratio is latched only when the counter wraps.
module clkdiv_phase_ctr
  import clkdiv_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6,
  parameter int CW     = $clog2(DIV_HI)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          run_i,
  input  logic          sel_i,
  output logic [CW-1:0] pos_d_o,
  output ratio_e        mode_d_o
);

  localparam logic [CW-1:0] LAST_LO = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(DIV_HI - 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_d;
  logic [CW-1:0] last_pos;
  ratio_e        mode_q;
  ratio_e        mode_d;
  logic          wrap;

  always_comb begin
    last_pos = (mode_q == RATIO_HI) ? LAST_HI : LAST_LO;
    wrap     = (pos_q >= last_pos);
    pos_d    = pos_q;
    mode_d   = mode_q;
    if (run_i) begin
      if (wrap) begin
        pos_d  = '0;
        mode_d = ratio_e'(sel_i);
      end else begin
        pos_d  = pos_q + 1'b1;
      end
    end
  end

  // Reset to the final position so the first enabled edge wraps to zero.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pos_q  <= LAST_HI;
      mode_q <= RATIO_LO;
    end else if (run_i) begin
      pos_q  <= pos_d;
      mode_q <= mode_d;
    end
  end

  assign pos_d_o  = pos_d;
  assign mode_d_o = mode_d;

  AST_MODE_ONLY_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_q != $past(mode_q)) |-> (pos_q == '0)); // R5

  AST_IDLE_POS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!run_i && !$past(run_i)) |-> (pos_q == $past(pos_q))); // R7

endmodule

// File: rtl/clkdiv_out_stage.sv
`timescale 1ns/1ps
// Output registers. They decode the next position, and the phase pulse
// comes from the actual rise of both registered outputs.
module clkdiv_out_stage
  import clkdiv_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6,
  parameter int CW     = $clog2(DIV_HI)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          run_i,
  input  logic [CW-1:0] pos_d_i,
  input  ratio_e        mode_d_i,
  output logic          div2_o,
  output logic          divsel_o,
  output logic          phase_o
);

  localparam logic [CW-1:0] HALF_LO = CW'(DIV_LO / 2);
  localparam logic [CW-1:0] HALF_HI = CW'(DIV_HI / 2);

  logic [CW-1:0] half_pos;
  logic          d2_q, d2_d;
  logic          ds_q, ds_d;
  logic          ph_q, ph_d;
  logic          live_q, live_d;

  always_comb begin
    half_pos = (mode_d_i == RATIO_HI) ? HALF_HI : HALF_LO;
    d2_d     = run_i & ~pos_d_i[0];
    ds_d     = run_i & (pos_d_i < half_pos);
    ph_d     = d2_d & ~d2_q & ds_d & ~ds_q;
    live_d   = run_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      d2_q   <= 1'b0;
      ds_q   <= 1'b0;
      ph_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      d2_q   <= d2_d;
      ds_q   <= ds_d;
      ph_q   <= ph_d;
      live_q <= live_d;
    end
  end

  assign div2_o   = d2_q;
  assign divsel_o = ds_q;
  assign phase_o  = ph_q;

  AST_DIV2_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && live_q) |=> (div2_o != $past(div2_o))); // R1

  AST_SLOW_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && live_q) |=> (!$rose(divsel_o) || $rose(div2_o))); // R3

  AST_PHASE_ON_COMMON_RISE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    phase_o |-> (div2_o && divsel_o && !$past(div2_o) && !$past(divsel_o))); // R4

  AST_PHASE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    phase_o |=> !phase_o); // R4

  AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !run_i |=> (!div2_o && !divsel_o && !phase_o)); // R7

endmodule

// File: rtl/sel_clock_divider.sv
`timescale 1ns/1ps
module sel_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic mreset_i,
  input  logic en_n_i,
  input  logic sel6_i,
  output logic div2_o,
  output logic div46_o,
  output logic phase_o
);

  localparam int CW = $clog2(DIV_HI);

  logic          rst_n;
  logic          run;
  logic [CW-1:0] pos_d;
  ratio_e        mode_d;

  clkdiv_rst_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk_i    (clk_i),
    .mreset_i (mreset_i),
    .rst_n_o  (rst_n)
  );

  clkdiv_en_capture u_en_capture (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .en_n_i  (en_n_i),
    .run_o   (run)
  );

  clkdiv_phase_ctr #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI),
    .CW     (CW)
  ) u_phase_ctr (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .run_i    (run),
    .sel_i    (sel6_i),
    .pos_d_o  (pos_d),
    .mode_d_o (mode_d)
  );

  clkdiv_out_stage #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI),
    .CW     (CW)
  ) u_out_stage (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .run_i    (run),
    .pos_d_i  (pos_d),
    .mode_d_i (mode_d),
    .div2_o   (div2_o),
    .divsel_o (div46_o),
    .phase_o  (phase_o)
  );

  AST_RESET_FORCES_LOW: assert property (@(posedge clk_i)
    mreset_i |-> (!div2_o && !div46_o && !phase_o)); // R8

endmodule

// File: tb/sel_clock_divider_tb_top.sv
`timescale 1ns/1ps
module sel_clock_divider_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic mreset;
  logic en_n;
  logic sel6;
  logic div2, div46, phase;

  sel_clock_divider dut_i (
    .clk_i    (clk),
    .mreset_i (mreset),
    .en_n_i   (en_n),
    .sel6_i   (sel6),
    .div2_o   (div2),
    .div46_o  (div46),
    .phase_o  (phase)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [2:0] cur = '0;   // {div2, div46, phase}
  logic [2:0] prv = '0;

  typedef struct packed {
    logic       sel;
    logic [3:0] reps;
    logic [3:0] period;
    logic [3:0] high;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 4'd3, 4'd4, 4'd2},
    '{1'b1, 4'd3, 4'd6, 4'd3},
    '{1'b0, 4'd2, 4'd4, 4'd2},
    '{1'b1, 4'd2, 4'd6, 4'd3},
    '{1'b1, 4'd2, 4'd6, 4'd3},
    '{1'b0, 4'd1, 4'd4, 4'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: inputs act from posedge+15; outputs sampled at +5 and +15.
  task automatic tick();
    logic [2:0] early;
    @(posedge clk);
    #5;
    early = {div2, div46, phase};
    #10;
    prv = cur;
    cur = {div2, div46, phase};
    check("R6 outputs steady between rising edges", early, cur);
    check("R4 phase marks common rise", cur[0],
          cur[2] & ~prv[2] & cur[1] & ~prv[1]);
  endtask

  task automatic expect_out(input string req, input logic [2:0] e);
    check(req, cur, e);
  endtask

  task automatic next_phase(output int gap);
    gap = 0;
    do begin
      tick();
      gap++;
    end while (!cur[0] && gap < 40);
  endtask

  // Starts on a phase tick and runs to the next one.
  task automatic measure(output int gap, output int hi,
                         output int badtog, output int badrise);
    gap = 0; hi = cur[1]; badtog = 0; badrise = 0;
    do begin
      tick();
      gap++;
      if (cur[2] == prv[2]) badtog++;
      if (cur[1] && !prv[1] && !(cur[2] && !prv[2])) badrise++;
      if (!cur[0] && cur[1]) hi++;
    end while (!cur[0] && gap < 40);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int gap, hi, btog, brise;
    mreset = 1'b1;
    en_n   = 1'b0;
    sel6   = 1'b0;

    // Reset state (R8)
    repeat (3) tick();
    expect_out("R8 outputs low in reset", 3'b000);

    // Release: first coincident rise on the third edge (R8, R9)
    mreset = 1'b0;
    tick(); expect_out("R8 low one edge after release", 3'b000);
    tick(); expect_out("R8 low two edges after release", 3'b000);
    tick(); expect_out("R8 first common rise with phase", 3'b111);
    measure(gap, hi, btog, brise);
    check("R9 default period is 4", gap, 4);
    check("R9 default high time is 2", hi, 2);

    // Vector walk over ratios (R1, R2, R3)
    gap = 4;
    for (int v = 0; v < 6; v++) begin
      int old_period;
      old_period = gap;
      sel6 = VECS[v].sel;
      next_phase(gap);
      check("R5 running period keeps old ratio", gap, old_period);
      for (int r = 0; r < int'(VECS[v].reps); r++) begin
        measure(gap, hi, btog, brise);
        check("R2 period of div46", gap, int'(VECS[v].period));
        check("R2 high time of div46", hi, int'(VECS[v].high));
        check("R1 div2 toggles every edge", btog, 0);
        check("R3 div46 rises only with div2", brise, 0);
      end
    end

    // Mode change at a boundary, now in divide-by-4 (R5)
    sel6 = 1'b1;
    next_phase(gap);
    check("R5 boundary switch old period 4", gap, 4);
    measure(gap, hi, btog, brise);
    check("R5 new period 6 after switch", gap, 6);

    // Mode change in the middle of a divide-by-6 period (R5)
    tick();
    sel6 = 1'b0;
    next_phase(gap);
    check("R5 mid-period switch completes 6", gap + 1, 6);
    measure(gap, hi, btog, brise);
    check("R5 divide by 4 after mid switch", gap, 4);
    sel6 = 1'b1;
    next_phase(gap);
    measure(gap, hi, btog, brise);
    check("R2 divide by 6 restored", gap, 6);

    // Stop one cycle after a common rise, then resume (R6, R7)
    en_n = 1'b1;
    tick(); expect_out("R6 disable latency one edge", 3'b010);
    tick(); expect_out("R7 outputs low while off", 3'b000);
    repeat (3) tick();
    expect_out("R7 outputs stay low while off", 3'b000);
    en_n = 1'b0;
    tick(); expect_out("R6 enable latency one edge", 3'b000);
    tick(); expect_out("R7 resume from held position 2", 3'b111);
    tick(); expect_out("R7 resume position 3", 3'b000);
    tick(); expect_out("R7 resume position 4", 3'b100);
    tick(); expect_out("R7 resume position 5", 3'b000);
    tick(); expect_out("R7 resume wraps to common rise", 3'b111);

    // Random enable toggling, then full periods must return (R7)
    for (int i = 0; i < 60; i++) begin
      en_n = 1'($urandom_range(0, 1));
      repeat ($urandom_range(1, 7)) tick();
    end
    en_n = 1'b0;
    next_phase(gap);
    measure(gap, hi, btog, brise);
    check("R7 period intact after toggling", gap, 6);
    check("R7 high time intact after toggling", hi, 3);
    check("R3 alignment intact after toggling", brise, 0);

    // Asynchronous reset while both outputs are high (R8)
    mreset = 1'b1;
    #1;
    check("R8 asynchronous clear", {div2, div46, phase}, 0);
    tick(); tick();
    expect_out("R8 held in reset", 3'b000);
    mreset = 1'b0;
    tick(); expect_out("R8 low edge 1 after release", 3'b000);
    tick(); expect_out("R8 low edge 2 after release", 3'b000);
    tick(); expect_out("R8 rise on edge 3 after release", 3'b111);
    measure(gap, hi, btog, brise);
    check("R2 divide by 6 after reset", gap, 6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule